// File: doc/BRIEF.md
# Serial Receive Status and Flag Clearing

This block keeps the receive side state of an asynchronous serial controller. A deserializer hands it one assembled character at a time, with a valid strobe. While the receiver is enabled, each such character replaces the held character and raises the receive-full flag. If the previous character was never taken, the overrun flag is raised as well. Noise and framing indications travel with the character. An idle-line indication arrives as a separate pulse. The block only holds and clears these flags; it does not detect them.

The CPU acknowledges received data with a two-step read. A read of the status register records the flags that are set at that moment. A later read of the data register clears exactly those recorded flags. Any flag raised in between survives the data read. A character that arrives between the two reads cancels the recorded clear, so the following data read clears nothing. The recorded set is used once: a data read clears it. A receive interrupt request is raised while its enable is set and the full or overrun flag is set.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, statusFlags is 0, rxData is 0 and rxIrq is 0. The clear record is empty, so a data read clears nothing.
- R2: A character accepted at a clock edge (charValid and rxEnable high) sets the full flag, statusFlags bit 0. The same edge makes rxData equal to charData.
- R3: An accepted character sets the overrun flag, bit 1, when the full flag was already set before that edge. Otherwise the overrun flag keeps its value.
- R4: While rxEnable is low, charValid has no effect on rxData or on statusFlags.
- R5: A status read followed by a later data read clears exactly the flags that were set at the status read. A flag raised between the two reads stays set.
- R6: A data read with no status read recorded since reset or since the last data read clears no flag.
- R7: An accepted character empties the clear record. A later data read then clears nothing, unless a new status read comes first.
- R8: A status read on one cycle and a data read on the next cycle clear the flags recorded by that status read.
- R9: A status register write (statusWr) changes no flag and does not change rxData.
- R10: rxIrq is high exactly when rxIntEn is high and the full or overrun flag is set.
- R11: An accepted character ORs noiseIn into bit 3 and frameErrIn into bit 4. An idleDetect pulse sets bit 2 whether or not the receiver is enabled.
- R12: A data read empties the clear record. A second data read without a new status read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | Assembled character is present this cycle |
| charData | input | DATA_W | Assembled character |
| noiseIn | input | 1 | Noise seen on this character |
| frameErrIn | input | 1 | Framing error on this character |
| idleDetect | input | 1 | Idle line detected (pulse) |
| rxEnable | input | 1 | Receiver enable |
| rxIntEn | input | 1 | Receive interrupt enable |
| statusRd | input | 1 | CPU read of the status register |
| dataRd | input | 1 | CPU read of the data register |
| statusWr | input | 1 | CPU write to the status register |
| statusFlags | output | 5 | {framing, noise, idle, overrun, full} |
| rxData | output | DATA_W | Held character |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The assertions check several rules on every cycle:
- An accepted character sets the full flag and loads the held character.
- An arrival onto a full register raises overrun.
- No flag drops unless a recorded clear is applied.
- An applied clear removes every recorded flag.
- An arrival empties the record.
- A status write leaves the flags unchanged.

Only the bench scenarios can show the end-to-end ordering effects. These are: a flag raised between the two reads surviving, an arrival cancelling a pending clear, and the record being used only once. They also cover how interrupt enable, receive enable and error inputs combine over long random sequences.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int FLAG_W  = 5;
  localparam int F_FULL  = 0;
  localparam int F_OVR   = 1;
  localparam int F_IDLE  = 2;
  localparam int F_NOISE = 3;
  localparam int F_FRAME = 4;

  typedef logic [FLAG_W-1:0] flagVec_t;

  typedef struct packed {
    logic     accept;
    logic     setIdle;
    logic     applyClear;
    flagVec_t clrMask;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      charValid,
  input  logic      rxEnable,
  input  logic      idleDetect,
  input  logic      statusRd,
  input  logic      dataRd,
  input  flagVec_t  flagsNow,
  output rxStrobe_t strb
);
  flagVec_t maskQ;
  logic     acceptNow;

  assign acceptNow = charValid & rxEnable;

  always_comb begin
    strb.accept     = acceptNow;
    strb.setIdle    = idleDetect;
    strb.applyClear = dataRd & ~acceptNow & (|maskQ);
    strb.clrMask    = maskQ;
  end

  // Clear record: an arrival cancels it, a status read loads it,
  // a data read consumes it.
  always_ff @(posedge clk) begin
    if (!rstN)          maskQ <= '0;
    else if (acceptNow) maskQ <= '0;
    else if (statusRd)  maskQ <= flagsNow;
    else if (dataRd)    maskQ <= '0;
  end

  p_disabled_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !rxEnable) |-> !strb.accept);

  p_arrival_cancels_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (maskQ == '0));

  p_status_records_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strb.accept) |=> (maskQ == $past(flagsNow)));

  p_read_consumes_r12: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !statusRd) |=> (maskQ == '0));
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [DATA_W-1:0] charData,
  input  logic              noiseIn,
  input  logic              frameErrIn,
  output flagVec_t          flagsQ,
  output logic [DATA_W-1:0] holdQ
);
  flagVec_t setVec;
  flagVec_t clrVec;

  always_comb begin
    setVec          = '0;
    setVec[F_FULL]  = strb.accept;
    setVec[F_OVR]   = strb.accept & flagsQ[F_FULL];
    setVec[F_IDLE]  = strb.setIdle;
    setVec[F_NOISE] = strb.accept & noiseIn;
    setVec[F_FRAME] = strb.accept & frameErrIn;
    clrVec          = strb.applyClear ? strb.clrMask : '0;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagsQ[i] <= 1'b0;
      else       flagsQ[i] <= (flagsQ[i] & ~clrVec[i]) | setVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            holdQ <= '0;
    else if (strb.accept) holdQ <= charData;
  end

  p_full_on_arrival_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (flagsQ[F_FULL] && holdQ == $past(charData)));

  p_overrun_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && flagsQ[F_FULL]) |=> flagsQ[F_OVR]);

  p_clear_exact_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyClear && !strb.setIdle) |=> ((flagsQ & $past(strb.clrMask)) == '0));

  p_no_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.applyClear |=> (($past(flagsQ) & ~flagsQ) == '0));
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              noiseIn,
  input  logic              frameErrIn,
  input  logic              idleDetect,
  input  logic              rxEnable,
  input  logic              rxIntEn,
  input  logic              statusRd,
  input  logic              dataRd,
  input  logic              statusWr,
  output logic [4:0]        statusFlags,
  output logic [DATA_W-1:0] rxData,
  output logic              rxIrq
);
  rxStrobe_t strb;
  flagVec_t  flagsQ;

  serial_rx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .charValid  (charValid),
    .rxEnable   (rxEnable),
    .idleDetect (idleDetect),
    .statusRd   (statusRd),
    .dataRd     (dataRd),
    .flagsNow   (flagsQ),
    .strb       (strb)
  );

  serial_rx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .charData   (charData),
    .noiseIn    (noiseIn),
    .frameErrIn (frameErrIn),
    .flagsQ     (flagsQ),
    .holdQ      (rxData)
  );

  assign statusFlags = flagsQ;
  assign rxIrq       = rxIntEn & (flagsQ[F_FULL] | flagsQ[F_OVR]);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (statusFlags[F_FULL] || statusFlags[F_OVR]));

  p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && !charValid && !idleDetect && !dataRd) |=> $stable(statusFlags));
endmodule

// File: tb/serial_rx_status_test.sv
`timescale 1ns/1ps
module serial_rx_status_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cv = 0, nf = 0, fe = 0, idl = 0, en = 0, rie = 0, srd = 0, drd = 0, swr = 0;
  logic [DW-1:0] d = '0;
  logic [4:0] flags;
  logic [DW-1:0] rdat;
  logic irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [4:0] mFlags = '0;
  logic [4:0] mMask = '0;
  logic [DW-1:0] mData = '0;

  always #4 clk = ~clk;

  serial_rx_status #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .charValid(cv), .charData(d), .noiseIn(nf),
    .frameErrIn(fe), .idleDetect(idl), .rxEnable(en), .rxIntEn(rie),
    .statusRd(srd), .dataRd(drd), .statusWr(swr),
    .statusFlags(flags), .rxData(rdat), .rxIrq(irq)
  );

  task automatic compare(input string tag);
    logic expIrq;
    expIrq = rie & (mFlags[0] | mFlags[1]);
    nChecks++;
    if (flags !== mFlags || rdat !== mData || irq !== expIrq) begin
      nFails++;
      $display("FAIL %s: flags=%b data=%h irq=%b expected flags=%b data=%h irq=%b",
               tag, flags, rdat, irq, mFlags, mData, expIrq);
    end
  endtask

  // Apply current stimulus for one edge, update the model, check, clear pulses.
  task automatic tick(input string tag);
    logic acc;
    logic [4:0] nF, nM;
    acc = cv & en;
    nF = mFlags;
    if (drd && !acc) nF = nF & ~mMask;
    if (acc) begin
      nF[0] = 1'b1;
      if (mFlags[0]) nF[1] = 1'b1;
      if (nf) nF[3] = 1'b1;
      if (fe) nF[4] = 1'b1;
    end
    if (idl) nF[2] = 1'b1;
    if (acc) nM = '0;
    else if (srd) nM = mFlags;
    else if (drd) nM = '0;
    else nM = mMask;
    @(posedge clk);
    @(negedge clk);
    if (acc) mData = d;
    mFlags = nF;
    mMask = nM;
    compare(tag);
    cv = 0; nf = 0; fe = 0; idl = 0; srd = 0; drd = 0; swr = 0;
  endtask

  task automatic arrive(input logic [DW-1:0] v, input string tag);
    cv = 1; d = v; tick(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rie = 1;
    compare("R1 reset state");
    drd = 1; tick("R1 data read after reset clears nothing");

    en = 1;
    arrive(8'hA5, "R2 first arrival sets full");
    arrive(8'h3C, "R3 arrival onto full sets overrun");

    en = 0;
    arrive(8'hFF, "R4 arrival while disabled ignored");
    en = 1;

    srd = 1; tick("R5 status read records");
    idl = 1; tick("R5 idle raised between reads");
    drd = 1; tick("R5 data read clears recorded only");
    if (flags !== 5'b00100) begin
      nFails++;
      $display("FAIL R5: flags=%b expected=%b", flags, 5'b00100);
    end
    nChecks++;

    drd = 1; tick("R6 data read without status read");

    cv = 1; d = 8'h11; nf = 1; tick("R11 noise captured");
    srd = 1; tick("R7 status read");
    arrive(8'h22, "R7 arrival cancels pending clear");
    drd = 1; tick("R7 data read clears nothing");

    srd = 1; tick("R8 status read");
    drd = 1; tick("R8 adjacent data read clears");
    nChecks++;
    if (flags !== 5'b00000) begin
      nFails++;
      $display("FAIL R8: flags=%b expected=%b", flags, 5'b00000);
    end

    arrive(8'h5A, "R12 arrival");
    srd = 1; tick("R12 status read");
    drd = 1; tick("R12 first data read");
    idl = 1; tick("R12 idle pulse");
    drd = 1; tick("R12 second data read clears nothing");

    arrive(8'h77, "R9 set full");
    swr = 1; tick("R9 status write ignored");
    swr = 1; d = 8'h00; tick("R9 status write ignored again");

    rie = 0; tick("R10 irq masked");
    rie = 1; tick("R10 irq enabled");

    en = 0;
    idl = 1; tick("R11 idle sets while disabled");
    en = 1;
    cv = 1; d = 8'h99; fe = 1; nf = 1; tick("R11 framing and noise captured");

    for (int i = 0; i < 4000; i++) begin
      cv  = ($urandom % 4) == 0;
      d   = DW'($urandom);
      nf  = ($urandom % 4) == 0;
      fe  = ($urandom % 4) == 0;
      idl = ($urandom % 16) == 0;
      srd = ($urandom % 4) == 0;
      drd = ($urandom % 4) == 0;
      swr = ($urandom % 8) == 0;
      en  = ($urandom % 8) != 0;
      rie = ($urandom % 2) == 0;
      tick("R3 R5 R7 R10 random sweep");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule